// File: doc/BRIEF.md
# Byte-Serial Time Snapshot Sender

This block keeps a free-running time of day as a 32-bit seconds count and a 20-bit microseconds count. A prescaler counts a parameter number of clocks per microsecond. When the microsecond count reaches its last value, it returns to zero and the seconds count goes up by one in that same clock.

A client pulses a one-cycle request to ask for the current time. The block then copies seconds and microseconds together, in the clock that accepts the request. In the next clock it raises a one-cycle announce strobe. After that it sends an eight-byte message on the byte output, one byte per clock. The four seconds bytes come first, then the four microseconds bytes, and each value is sent least-significant byte first. The top microseconds byte is always zero.

A request that arrives while a message is in flight is ignored. The byte output is zero whenever no message byte is being sent. Everything runs on a single clock with a synchronous active-low reset.

Top module: `ts_snap_sender`

## Requirements
- R1: While reset is asserted, and in the first clock after it, the strobe is low and the byte output is zero. Reset clears both time counts, so a snapshot taken j clocks after reset is released (j below one second) reports seconds 0 and microseconds floor(j / CLKS_PER_US).
- R2: The microseconds count advances by exactly one every CLKS_PER_US clocks. Between advances, neither count changes.
- R3: The microseconds count runs from 0 to US_PER_SEC-1 (default 999999). In the clock where it advances past US_PER_SEC-1 it returns to 0, and seconds increments by one in that same clock.
- R4: A request sampled high at a clock edge while the block is idle makes the strobe high for exactly the one clock that follows that edge.
- R5: The eight message bytes appear on the eight clocks directly after the strobe clock, in this order: seconds bits 7:0, 15:8, 23:16, 31:24, then microseconds bits 7:0, 15:8, 23:16, 31:24. The strobe is low during all eight.
- R6: The eighth byte is always 0x00, and the upper nibble of the seventh byte is always zero.
- R7: The message carries the seconds and microseconds values as they stood at the accepting edge, both taken from the same edge. Counting that goes on during transmission does not change the message.
- R8: A request sampled during the strobe clock, or during any of the first seven byte clocks, is ignored and leaves the message unchanged. A request sampled at the edge that ends the eighth byte is accepted, so its strobe directly follows the eighth byte.
- R9: The byte output is 0x00 in every clock that does not carry a message byte, the strobe clock included.
- R10: Asserting reset during a message stops it. From the next clock the strobe is low and the byte output is zero, and the time counts restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for counters and message output |
| rst_n | input | 1 | Synchronous active-low reset |
| snap_req | input | 1 | One-cycle request for a time snapshot |
| snap_stb | output | 1 | One-cycle announce, one clock before the first byte |
| snap_byte | output | 8 | Message byte, zero when idle |

## Verification
The hardest state to reach from the ports is a snapshot whose accepting edge is the very edge where microseconds wraps and seconds steps. Only a request placed on exactly that clock shows that both values were taken before the step. The bench instantiates the block with three clocks per microsecond and ten microseconds per second. It follows the time in its own model and waits for the clock where the model sits at the last prescaler count of the last microsecond, then issues the request there and again just after. Requests placed in the strobe clock, in the middle of a message, in the last ignored byte clock and on the eighth byte show where the acceptance boundary lies.

// File: rtl/ts_snap_pkg.sv
// Shared widths and types for the time snapshot sender.
// Assumes a message of four seconds bytes followed by four microseconds bytes.
package ts_snap_pkg;
    localparam int SEC_W     = 32;
    localparam int US_W      = 20;
    localparam int BYTE_W    = 8;
    localparam int MSG_BYTES = 8;
    localparam int MSG_W     = MSG_BYTES * BYTE_W;
    localparam int PHASE_W   = $clog2(MSG_BYTES + 1);

    typedef logic [SEC_W-1:0]  sec_t;
    typedef logic [US_W-1:0]   usec_t;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ts_prescaler.sv
// Microsecond prescaler: gives a one-clock tick every CLKS_PER_US clocks.
// Assumes CLKS_PER_US >= 1; with 1 the tick is high on every clock.
module ts_prescaler #(
    parameter int CLKS_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);

    logic [CW-1:0] div_q;

    // Count clocks inside one microsecond, restart after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)             div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/ts_time_counter.sv
// Seconds / microseconds time keeper advanced by the prescaler tick.
// Assumes US_PER_SEC fits in the microseconds width of the package.
module ts_time_counter
    import ts_snap_pkg::*;
#(
    parameter int US_PER_SEC = 1000000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    output sec_t  sec_q,
    output usec_t usec_q
);
    localparam usec_t US_LAST = US_W'(US_PER_SEC - 1);

    // Advance microseconds on each tick, carry into seconds at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= '0;
            usec_q <= '0;
        end else if (tick) begin
            if (usec_q == US_LAST) begin
                usec_q <= '0;
                sec_q  <= sec_q + 1'b1;
            end else begin
                usec_q <= usec_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ts_msg_sender.sv
// Latches a time snapshot on an accepted request and sends it as a strobe
// followed by eight bytes, least significant first, seconds before usec.
// Assumes requests are one-cycle pulses; requests while busy are dropped.
module ts_msg_sender
    import ts_snap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req,
    input  sec_t  sec_in,
    input  usec_t usec_in,
    output logic  stb,
    output byte_t data
);
    localparam logic [PHASE_W-1:0] LAST_PH = PHASE_W'(MSG_BYTES);

    logic [PHASE_W-1:0] phase_q;
    logic [MSG_W-1:0]   shreg_q;
    logic               accept;

    assign accept = req && (phase_q == '0);

    // Track message position: 0 idle, 1..MSG_BYTES next byte to send.
    always_ff @(posedge clk) begin
        if (!rst_n)                phase_q <= '0;
        else if (accept)           phase_q <= PHASE_W'(1);
        else if (phase_q == LAST_PH) phase_q <= '0;
        else if (phase_q != '0)    phase_q <= phase_q + 1'b1;
    end

    // Load the snapshot on accept, shift one byte out per message clock.
    always_ff @(posedge clk) begin
        if (!rst_n)             shreg_q <= '0;
        else if (accept)        shreg_q <= {{(MSG_W - SEC_W - US_W){1'b0}}, usec_in, sec_in};
        else if (phase_q != '0) shreg_q <= shreg_q >> BYTE_W;
    end

    // Drive the announce strobe and the byte output (zero when idle).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb  <= 1'b0;
            data <= '0;
        end else begin
            stb  <= accept;
            data <= (phase_q != '0) ? shreg_q[BYTE_W-1:0] : '0;
        end
    end
endmodule

// File: rtl/ts_snap_sender.sv
// Top: free-running seconds/microseconds time with byte-serial snapshot output.
// Assumes one clock for everything and a synchronous active-low reset.
module ts_snap_sender
    import ts_snap_pkg::*;
#(
    parameter int CLKS_PER_US = 100,
    parameter int US_PER_SEC  = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       snap_req,
    output logic       snap_stb,
    output logic [7:0] snap_byte
);
    logic  us_tick;
    sec_t  cur_sec;
    usec_t cur_usec;

    ts_prescaler #(.CLKS_PER_US(CLKS_PER_US)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (us_tick)
    );

    ts_time_counter #(.US_PER_SEC(US_PER_SEC)) u_time (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (us_tick),
        .sec_q  (cur_sec),
        .usec_q (cur_usec)
    );

    ts_msg_sender u_send (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (snap_req),
        .sec_in  (cur_sec),
        .usec_in (cur_usec),
        .stb     (snap_stb),
        .data    (snap_byte)
    );
endmodule

// File: rtl/ts_snap_sender_chk.sv
// Property checker for ts_snap_sender, attached by bind below.
// Keeps its own count of message clocks after each strobe.
module ts_snap_sender_chk
    import ts_snap_pkg::*;
#(
    parameter int US_PER_SEC = 1000000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       snap_stb,
    input logic [7:0] snap_byte,
    input logic       tick,
    input sec_t       sec,
    input usec_t      usec
);
    localparam usec_t US_LAST = US_W'(US_PER_SEC - 1);

    logic [3:0] pos_q;

    // Position in the message: 1..8 are the byte clocks after a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                         pos_q <= '0;
        else if (snap_stb)                  pos_q <= 4'd1;
        else if (pos_q != 0 && pos_q != 8)  pos_q <= pos_q + 4'd1;
        else                                pos_q <= '0;
    end

    AST_RST_QUIET:  assert property (@(posedge clk) !rst_n |=> (!snap_stb && snap_byte == 8'h00)); // R10
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) snap_stb |=> !snap_stb); // R4
    AST_STB_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) snap_stb |-> pos_q == 4'd0); // R8
    AST_IDLE_ZERO:  assert property (@(posedge clk) disable iff (!rst_n) pos_q == 4'd0 |-> snap_byte == 8'h00); // R9
    AST_TOP_BYTE:   assert property (@(posedge clk) disable iff (!rst_n) pos_q == 4'd8 |-> snap_byte == 8'h00); // R6
    AST_U2_NIBBLE:  assert property (@(posedge clk) disable iff (!rst_n) pos_q == 4'd7 |-> snap_byte[7:4] == 4'h0); // R6
    AST_US_RANGE:   assert property (@(posedge clk) disable iff (!rst_n) usec <= US_LAST); // R3
    AST_US_WRAP:    assert property (@(posedge clk) disable iff (!rst_n)
                        (tick && usec == US_LAST) |=> (usec == '0 && sec == $past(sec) + 1'b1)); // R3
    AST_TIME_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
                        !tick |=> ($stable(sec) && $stable(usec))); // R2
endmodule

bind ts_snap_sender ts_snap_sender_chk #(.US_PER_SEC(US_PER_SEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .snap_stb  (snap_stb),
    .snap_byte (snap_byte),
    .tick      (us_tick),
    .sec       (cur_sec),
    .usec      (cur_usec)
);

// File: tb/tb_ts_snap_sender.sv
// Directed bench for ts_snap_sender; inputs change and outputs are read at negedge.
module tb_ts_snap_sender;
    localparam int CPU = 3;
    localparam int UPS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       snap_req = 1'b0;
    logic       snap_stb;
    logic [7:0] snap_byte;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ts_snap_sender #(.CLKS_PER_US(CPU), .US_PER_SEC(UPS)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap_req  (snap_req),
        .snap_stb  (snap_stb),
        .snap_byte (snap_byte)
    );

    // Reference time from R1..R3.
    int          m_pc;
    int          m_us;
    logic [31:0] m_sec;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_pc <= 0; m_us <= 0; m_sec <= '0;
        end else if (m_pc == CPU - 1) begin
            m_pc <= 0;
            if (m_us == UPS - 1) begin m_us <= 0; m_sec <= m_sec + 1; end
            else m_us <= m_us + 1;
        end else begin
            m_pc <= m_pc + 1;
        end
    end

    logic [31:0] nxt_s, nxt_u;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge: pulse a request, return in the strobe clock.
    task automatic start_req(output logic [31:0] es, output logic [31:0] eu);
        snap_req = 1'b1;
        es = m_sec;
        eu = 32'(m_us);
        @(negedge clk);
        snap_req = 1'b0;
    endtask

    // Check strobe and eight bytes; poke raises a request in clock poke
    // (0 = strobe clock, 1..8 = byte clocks). poke 8 chains a new message.
    task automatic recv(input logic [31:0] es, input logic [31:0] eu, input int poke);
        logic [63:0] w;
        w = {eu, es};
        chk("R4 strobe high", 32'(snap_stb), 1);
        chk("R9 byte zero in strobe clock", 32'(snap_byte), 0);
        if (poke == 0) snap_req = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            snap_req = 1'b0;
            chk($sformatf("R5 R7 byte%0d", i), 32'(snap_byte), 32'(w[8*i +: 8]));
            chk($sformatf("R4 R8 strobe low at byte%0d", i), 32'(snap_stb), 0);
            if (i == 7) chk("R6 top byte zero", 32'(snap_byte), 0);
            if (i == 6) chk("R6 u2 nibble zero", 32'(snap_byte[7:4]), 0);
            if (poke == i + 1) begin
                snap_req = 1'b1;
                if (poke == 8) begin nxt_s = m_sec; nxt_u = 32'(m_us); end
            end
        end
        @(negedge clk);
        snap_req = 1'b0;
        if (poke != 8) begin
            for (int k = 0; k < 3; k++) begin
                chk("R8 no strobe after message", 32'(snap_stb), 0);
                chk("R9 idle byte zero", 32'(snap_byte), 0);
                @(negedge clk);
            end
        end
    endtask

    task automatic t_reset;
        logic [31:0] es, eu;
        repeat (4) @(negedge clk);
        chk("R1 strobe in reset", 32'(snap_stb), 0);
        chk("R1 byte in reset", 32'(snap_byte), 0);
        rst_n = 1'b1;
        chk("R1 strobe first clock", 32'(snap_stb), 0);
        repeat (7) @(negedge clk);
        start_req(es, eu);
        chk("R1 seconds after reset", es, 0);
        chk("R2 usec after 7 clocks", eu, 2);
        recv(32'd0, 32'd2, -1);
    endtask

    task automatic t_spaced;
        logic [31:0] es, eu;
        int gaps[4] = '{1, 5, 11, 17};
        foreach (gaps[g]) begin
            repeat (gaps[g]) @(negedge clk);
            start_req(es, eu);
            recv(es, eu, -1);
        end
    endtask

    task automatic t_ignore;
        logic [31:0] es, eu;
        int pokes[3] = '{0, 3, 7};
        foreach (pokes[p]) begin
            start_req(es, eu);
            recv(es, eu, pokes[p]);  // R8 requests dropped
        end
    endtask

    task automatic t_back2back;
        logic [31:0] es, eu;
        start_req(es, eu);
        recv(es, eu, 8);
        recv(nxt_s, nxt_u, -1);      // R8 accepted after eighth byte
    endtask

    task automatic t_wrap;
        logic [31:0] es, eu, s0;
        while (!(m_us == UPS - 1 && m_pc == CPU - 1)) @(negedge clk);
        s0 = m_sec;
        start_req(es, eu);
        chk("R3 usec before wrap", eu, UPS - 1);
        chk("R3 seconds before wrap", es, s0);
        recv(es, eu, -1);
        start_req(es, eu);
        chk("R3 seconds stepped", es, s0 + 1);
        chk("R3 usec restarted", 32'(eu < UPS - 1), 1);
        recv(es, eu, -1);
    endtask

    task automatic t_abort;
        logic [31:0] es, eu;
        start_req(es, eu);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 strobe after abort", 32'(snap_stb), 0);
        chk("R10 byte after abort", 32'(snap_byte), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (7) @(negedge clk);
        start_req(es, eu);
        chk("R10 seconds restarted", es, 0);
        chk("R10 usec restarted", eu, 2);
        recv(es, eu, -1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_spaced();
        t_ignore();
        t_back2back();
        t_wrap();
        t_abort();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule